// File: doc/BRIEF.md
# Prefixed Shift and Rotate Executor

This unit carries out the shift and rotate group that an 8-bit processor reaches through a prefix opcode. The processor fetches the prefix byte. It then hands the low six bits of the following opcode byte to this unit with a one-cycle start strobe.

Bits [5:3] of that code pick the operation and bits [2:0] pick the operand. The unit reads the operand from a general register through a register file port, or from the memory byte addressed by the HL pair. It computes the shifted or rotated byte and writes it back to where it came from. It also writes a new set of the four flags.

A register operand completes in one clock, which is two machine cycles once the prefix fetch is counted. A memory operand runs a read-modify-write sequence over three clocks, four machine cycles in total. Operation codes outside the group are refused. A refused code writes nothing and raises an unsupported indication when it completes.

Top module: `shiftRotExec`

## Requirements
- R1: Operation code 000 rotates left circularly. Bit 7 goes to both bit 0 and carry.
- R2: Operation code 001 rotates right circularly. Bit 0 goes to both bit 7 and carry.
- R3: Operation code 100 shifts left with 0 entering bit 0. The old bit 7 goes to carry.
- R4: Operation code 101 shifts right arithmetically. Bit 7 is kept, and the old bit 0 goes to carry.
- R5: Operation code 111 shifts right logically with 0 entering bit 7. The old bit 0 goes to carry.
- R6: Each completed operation writes flagsOut = {Z,N,H,C} with flagWrEn high. N and H are 0. Z is 1 exactly when the 8-bit result is 0.
- R7: Operand code 110 selects the memory byte at hlAddr. That byte is read and written back to the same address. Codes 000 to 101 and 111 select register index = code (B,C,D,E,H,L,-,A). The result is written back to that same index.
- R8: With a register operand, regWrEn, flagWrEn and a one-cycle done are all high in the cycle right after the start edge.
- R9: With a memory operand, memRdEn is high one cycle after the start edge. memWrEn, flagWrEn and done are high three cycles after the start edge.
- R10: Operation codes 010, 011 and 110 raise done and unsupported one cycle after start. They raise no register, memory or flag write.
- R11: After reset, busy and done are low. busy is high from the cycle after start through the done cycle. A start seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin executing opCode |
| opCode | input | 6 | Operation code [5:3] and operand code [2:0] |
| hlAddr | input | 16 | Memory address held in the HL pair |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| unsupported | output | 1 | Operation code refused, valid with done |
| regRdIdx | output | 3 | Register file read index |
| regRdData | input | 8 | Register file read data, combinational |
| regWrEn | output | 1 | Register file write strobe |
| regWrIdx | output | 3 | Register file write index |
| regWrData | output | 8 | Register file write data |
| memRdEn | output | 1 | Memory read strobe, data valid next cycle |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | 16 | Memory address |
| memRdData | input | 8 | Memory read data |
| memWrData | output | 8 | Memory write data |
| flagWrEn | output | 1 | Flag register write strobe |
| flagsOut | output | 4 | New flags {Z,N,H,C} |

## Verification
The bench runs every operation code against all 256 byte values, through both a register operand and the memory operand. This catches rotates that drop the wrapped bit, arithmetic shifts that lose the sign bit, and zero flags that test the input byte instead of the result.

It tracks the clock of each strobe from start. A read-modify-write that samples the read data one cycle early would write stale bytes. A latency off by one would show up as a misplaced done.

Refused codes are checked for any stray write strobe. A second start pulse sent in the middle of a memory operation must not produce an extra completion or change the result.

// File: rtl/shiftRotPkg.sv
package shiftRotPkg;
  localparam logic [2:0] OP_RLC = 3'b000;
  localparam logic [2:0] OP_RRC = 3'b001;
  localparam logic [2:0] OP_SLA = 3'b100;
  localparam logic [2:0] OP_SRA = 3'b101;
  localparam logic [2:0] OP_SRL = 3'b111;
  localparam logic [2:0] SEL_MEM = 3'b110;

  typedef struct packed {
    logic loadOp;
    logic rdMem;
    logic captMem;
    logic wrMem;
    logic wrReg;
    logic wrFlags;
  } ctlStrb_t;

  function automatic logic opKnown(input logic [2:0] op);
    return (op == OP_RLC) || (op == OP_RRC) || (op == OP_SLA) ||
           (op == OP_SRA) || (op == OP_SRL);
  endfunction
endpackage

// File: rtl/shiftRotCtl.sv
module shiftRotCtl
  import shiftRotPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [5:0] opCode,
  output ctlStrb_t   strb,
  output logic       busy,
  output logic       done,
  output logic       unsupported
);
  typedef enum logic [2:0] {ST_IDLE, ST_REG, ST_MRD, ST_MCAP, ST_MWR, ST_BAD} state_t;
  state_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE: if (start) begin
        if (!opKnown(opCode[5:3]))        stateNxt = ST_BAD;
        else if (opCode[2:0] == SEL_MEM)  stateNxt = ST_MRD;
        else                              stateNxt = ST_REG;
      end
      ST_MRD:  stateNxt = ST_MCAP;
      ST_MCAP: stateNxt = ST_MWR;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strb = '0;
    strb.loadOp  = (state == ST_IDLE) && start;
    strb.rdMem   = (state == ST_MRD);
    strb.captMem = (state == ST_MCAP);
    strb.wrMem   = (state == ST_MWR);
    strb.wrReg   = (state == ST_REG);
    strb.wrFlags = (state == ST_REG) || (state == ST_MWR);
  end

  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_REG) || (state == ST_MWR) || (state == ST_BAD);
  assign unsupported = (state == ST_BAD);

  // R11
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> busy);
  // R11
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rstN) $rose(busy) |-> $past(start));
  // R9
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rstN) strb.wrMem |-> $past(strb.rdMem, 2));
  // R10
  unsup_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    unsupported |-> !(strb.wrReg || strb.wrMem || strb.wrFlags));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
endmodule

// File: rtl/shiftRotDp.sv
module shiftRotDp
  import shiftRotPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [CODE_W-1:0] opCode,
  input  logic [ADDR_W-1:0] hlAddr,
  input  logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [2:0]        regRdIdx,
  output logic              regWrEn,
  output logic [2:0]        regWrIdx,
  output logic [DATA_W-1:0] regWrData,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              flagWrEn,
  output logic [3:0]        flagsOut
);
  localparam int MSB = DATA_W - 1;

  logic [CODE_W-1:0] opReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] memByte, srcByte, resByte;
  logic              carryOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg   <= '0;
      addrReg <= '0;
      memByte <= '0;
    end else begin
      if (strb.loadOp) begin
        opReg   <= opCode;
        addrReg <= hlAddr;
      end
      if (strb.captMem) memByte <= memRdData;
    end
  end

  assign srcByte = strb.wrMem ? memByte : regRdData;

  always_comb begin
    case (opReg[5:3])
      OP_RLC:  begin resByte = {srcByte[MSB-1:0], srcByte[MSB]}; carryOut = srcByte[MSB]; end
      OP_RRC:  begin resByte = {srcByte[0], srcByte[MSB:1]};     carryOut = srcByte[0];   end
      OP_SLA:  begin resByte = {srcByte[MSB-1:0], 1'b0};         carryOut = srcByte[MSB]; end
      OP_SRA:  begin resByte = {srcByte[MSB], srcByte[MSB:1]};   carryOut = srcByte[0];   end
      OP_SRL:  begin resByte = {1'b0, srcByte[MSB:1]};           carryOut = srcByte[0];   end
      default: begin resByte = srcByte;                          carryOut = 1'b0;         end
    endcase
  end

  assign regRdIdx  = opReg[2:0];
  assign regWrIdx  = opReg[2:0];
  assign regWrEn   = strb.wrReg;
  assign regWrData = resByte;
  assign memRdEn   = strb.rdMem;
  assign memWrEn   = strb.wrMem;
  assign memAddr   = addrReg;
  assign memWrData = resByte;
  assign flagWrEn  = strb.wrFlags;
  assign flagsOut  = {resByte == '0, 1'b0, 1'b0, carryOut};

  // R7
  mem_same_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> memAddr == $past(memAddr, 2));
endmodule

// File: rtl/shiftRotExec.sv
module shiftRotExec
  import shiftRotPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [5:0]        opCode,
  input  logic [ADDR_W-1:0] hlAddr,
  output logic              busy,
  output logic              done,
  output logic              unsupported,
  output logic [2:0]        regRdIdx,
  input  logic [DATA_W-1:0] regRdData,
  output logic              regWrEn,
  output logic [2:0]        regWrIdx,
  output logic [DATA_W-1:0] regWrData,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] memWrData,
  output logic              flagWrEn,
  output logic [3:0]        flagsOut
);
  ctlStrb_t strb;

  shiftRotCtl ctl_i (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode),
    .strb(strb), .busy(busy), .done(done), .unsupported(unsupported)
  );

  shiftRotDp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CODE_W(6)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .opCode(opCode), .hlAddr(hlAddr),
    .regRdData(regRdData), .memRdData(memRdData),
    .regRdIdx(regRdIdx), .regWrEn(regWrEn), .regWrIdx(regWrIdx), .regWrData(regWrData),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData),
    .flagWrEn(flagWrEn), .flagsOut(flagsOut)
  );
endmodule

// File: tb/shiftRotExec_tb_top.sv
module shiftRotExec_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  opCode = '0;
  logic [15:0] hlAddr = '0;
  logic        busy, done, unsupported, regWrEn, memRdEn, memWrEn, flagWrEn;
  logic [2:0]  regRdIdx, regWrIdx;
  logic [7:0]  regRdData, regWrData, memWrData;
  logic [7:0]  memRdData = '0;
  logic [15:0] memAddr;
  logic [3:0]  flagsOut;

  logic [7:0] regArr [0:7];
  logic [7:0] memArr [0:255];

  int nChecks = 0;
  int nFails  = 0;
  int edgeCnt = 0;
  bit finished = 0;

  typedef struct {
    int          kind;
    logic [2:0]  idx;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [3:0]  flags;
    int          startCnt;
    string       tag;
  } exp_t;
  exp_t sbQ[$];

  always #10 clk = ~clk;

  shiftRotExec dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .hlAddr(hlAddr),
    .busy(busy), .done(done), .unsupported(unsupported),
    .regRdIdx(regRdIdx), .regRdData(regRdData), .regWrEn(regWrEn), .regWrIdx(regWrIdx),
    .regWrData(regWrData), .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memRdData(memRdData), .memWrData(memWrData), .flagWrEn(flagWrEn), .flagsOut(flagsOut)
  );

  assign regRdData = regArr[regRdIdx];

  always @(posedge clk) begin
    edgeCnt <= edgeCnt + 1;
    if (regWrEn) regArr[regWrIdx] <= regWrData;
    if (memRdEn) memRdData <= memArr[memAddr[7:0]];
    if (memWrEn) memArr[memAddr[7:0]] <= memWrData;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [8:0] refCalc(input logic [2:0] op, input logic [7:0] v);
    case (op)
      3'b000:  return {v[7], v[6:0], v[7]};
      3'b001:  return {v[0], v[0], v[7:1]};
      3'b100:  return {v[7], v[6:0], 1'b0};
      3'b101:  return {v[0], v[7], v[7:1]};
      default: return {v[0], 1'b0, v[7:1]};
    endcase
  endfunction

  function automatic string opTag(input logic [2:0] op);
    case (op)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b100:  return "R3";
      3'b101:  return "R4";
      3'b111:  return "R5";
      default: return "R10";
    endcase
  endfunction

  // monitor: pops the expected item on each completion
  always @(negedge clk) begin
    if (rstN && memRdEn && sbQ.size() > 0) begin
      chk(memAddr == sbQ[0].addr, "R7 read address", memAddr, sbQ[0].addr);
      chk(edgeCnt - sbQ[0].startCnt == 1, "R9 read cycle", edgeCnt - sbQ[0].startCnt, 1);
    end
    if (rstN && done) begin
      if (sbQ.size() == 0) begin
        chk(0, "R11 unexpected done", 1, 0);
      end else begin
        exp_t e;
        int lat;
        e = sbQ.pop_front();
        lat = edgeCnt - e.startCnt;
        chk(busy, "R11 busy at done", busy, 1);
        if (e.kind == 2) begin
          chk(unsupported, "R10 unsupported", unsupported, 1);
          chk(!regWrEn && !memWrEn && !flagWrEn, "R10 no writes",
              {regWrEn, memWrEn, flagWrEn}, 0);
          chk(lat == 1, "R10 latency", lat, 1);
        end else begin
          chk(!unsupported, "R10 unsupported low", unsupported, 0);
          chk(flagWrEn && flagsOut == e.flags, "R6 flags", flagsOut, e.flags);
          if (e.kind == 0) begin
            chk(regWrEn && !memWrEn && regWrIdx == e.idx, "R7 register target",
                {regWrEn, memWrEn, regWrIdx}, {2'b10, e.idx});
            chk(regWrData == e.data, e.tag, regWrData, e.data);
            chk(lat == 1, "R8 latency", lat, 1);
          end else begin
            chk(memWrEn && !regWrEn && memAddr == e.addr, "R7 memory target",
                memAddr, e.addr);
            chk(memWrData == e.data, e.tag, memWrData, e.data);
            chk(lat == 3, "R9 latency", lat, 3);
          end
        end
      end
    end
  end

  // driver: pushes expectation, pulses start, waits for idle
  task automatic runOp(input logic [2:0] op, input logic [2:0] sel, input logic [7:0] v,
                       input logic [15:0] addr);
    exp_t e;
    logic [8:0] r;
    @(negedge clk);
    while (busy) @(negedge clk);
    if (sel == 3'b110) memArr[addr[7:0]] = v;
    else               regArr[sel] = v;
    r = refCalc(op, v);
    e.kind = (op == 3'b010 || op == 3'b011 || op == 3'b110) ? 2 : (sel == 3'b110 ? 1 : 0);
    e.idx = sel;
    e.addr = addr;
    e.data = r[7:0];
    e.flags = {r[7:0] == 8'h00, 1'b0, 1'b0, r[8]};
    e.startCnt = edgeCnt;
    e.tag = opTag(op);
    sbQ.push_back(e);
    opCode = {op, sel};
    hlAddr = addr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) regArr[i] = 8'h00;
    for (int i = 0; i < 256; i++) memArr[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R11 reset idle", {busy, done}, 0);
    chk(!regWrEn && !memWrEn && !flagWrEn, "R11 reset no writes",
        {regWrEn, memWrEn, flagWrEn}, 0);
    rstN = 1'b1;

    // register operands, all codes and all byte values (R1-R6, R8, R10 via tags)
    for (int op = 0; op < 8; op++) begin
      for (int v = 0; v < 256; v++) begin
        logic [2:0] sel;
        sel = 3'(v % 8);
        if (sel == 3'b110) sel = 3'b111;
        runOp(3'(op), sel, 8'(v), 16'h0000);
      end
    end

    // memory operand, all codes and all byte values (R7, R9)
    for (int op = 0; op < 8; op++) begin
      for (int v = 0; v < 256; v++) begin
        runOp(3'(op), 3'b110, 8'(v), {8'h5C, 8'(v) ^ 8'h3B});
      end
    end

    // refused code leaves memory untouched (R10)
    memArr[8'h44] = 8'hC3;
    runOp(3'b011, 3'b110, 8'hC3, 16'h1244);
    chk(memArr[8'h44] == 8'hC3, "R10 memory unchanged", memArr[8'h44], 8'hC3);

    // start while busy is ignored (R11)
    begin
      exp_t e;
      @(negedge clk);
      memArr[8'h20] = 8'h81;
      e.kind = 1; e.idx = 3'b110; e.addr = 16'h3420; e.data = 8'h03;
      e.flags = 4'b0001; e.startCnt = edgeCnt; e.tag = "R1";
      sbQ.push_back(e);
      opCode = 6'b000110; hlAddr = 16'h3420; start = 1'b1;
      @(negedge clk);
      opCode = 6'b001111; hlAddr = 16'h3499; start = 1'b1;
      chk(busy, "R11 busy mid-operation", busy, 1);
      @(negedge clk);
      start = 1'b0;
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(!done && !busy, "R11 no extra completion", {done, busy}, 0);
      chk(sbQ.size() == 0, "R11 scoreboard drained", sbQ.size(), 0);
      chk(memArr[8'h20] == 8'h03, "R11 memory result", memArr[8'h20], 8'h03);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule